// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a 32-bit down-counter that a processor reaches through a simple register bus. The bus has an address, a write strobe, write data and a combinational read-data return. Software writes a start value, sets a prescale divider and chooses one of two behaviours at zero. In one-shot behaviour the counter parks at zero. In periodic behaviour it refills itself from the stored start value on the tick after reaching zero.

Each arrival at zero sets a sticky event bit. Software clears that bit by writing a one to it. The event bit drives the interrupt line whenever the interrupt enable is set. The prescaler runs from the input clock and passes one decrement tick every P+1 clocks, where P is an 8-bit control field.

Top module: `cdt_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A write to offset 0x00 stores the reload value and, at the same clock edge, overwrites the live count (read at offset 0x04) with that value. This write takes priority over any tick in the same cycle.
- R3: The count changes only through an offset 0x00 write or a prescaler tick. Ticks occur only while control bit 0 (run) is 1; with run at 0 the count holds.
- R4: With run set, the prescaler gives one tick every P+1 clocks, where P is control bits 15:8 (P=0x3F divides by 64). The prescaler restarts from zero after any offset 0x00 write and while run is 0, so the first tick comes P+1 clocks after run is seen.
- R5: On a tick with the count at zero, the count takes the reload value if control bit 1 (reload) is 1, and stays at zero if it is 0.
- R6: A tick that moves the count from 1 to 0 sets the event flag, status bit 0 at offset 0x0C.
- R7: Writing offset 0x0C with data bit 0 at 1 clears the event flag. Writing 0 there leaves it unchanged.
- R8: If a clear write and a hardware set of the event flag fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the event flag and control bit 2 (interrupt enable) are both 1.
- R10: Offset 0x08 stores only bits 0, 1, 2 and 15:8 of a write. All other control bits read back as zero.
- R11: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero. Writes to those other offsets, and writes to the count offset 0x04, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, event flag gated by enable |

## Verification
Several rules are checked by the assertions on every clock, because each can be stated as a one-cycle rule:
- a load write taking effect on the next edge;
- the count holding or stepping down by exactly one;
- ticks occurring only while run is set;
- the prescaler clearing;
- parking at zero;
- the flag set on the 1-to-0 step;
- the one-to-clear behaviour;
- zero returned on unmapped reads.

Other properties only show up in the bench's scenarios, which compare the ports with a reference model on every clock:
- the exact spacing of ticks for several prescale values, including divide-by-64;
- the refill period in periodic mode;
- set-wins collisions across a burst of clear writes;
- control-field masking.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int PRESC_W = 8;

    localparam logic [15:0] OFF_LOAD  = 16'h0000;
    localparam logic [15:0] OFF_COUNT = 16'h0004;
    localparam logic [15:0] OFF_CTRL  = 16'h0008;
    localparam logic [15:0] OFF_STAT  = 16'h000C;

    // Control word layout, low 16 bits of the register
    typedef struct packed {
        logic [PRESC_W-1:0] prescale;  // bits 15:8
        logic [4:0]         rsvd;      // bits 7:3, never stored
        logic               irq_en;    // bit 2
        logic               reload;    // bit 1
        logic               run;       // bit 0
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOAD,
        SEL_COUNT,
        SEL_CTRL,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [15:0] off);
        case (off)
            OFF_LOAD:  return SEL_LOAD;
            OFF_COUNT: return SEL_COUNT;
            OFF_CTRL:  return SEL_CTRL;
            OFF_STAT:  return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_bits(input logic [15:0] bits);
        ctrl_t c;
        c = ctrl_t'(bits);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               clr,
    input  logic [PRESC_W-1:0] divisor,
    output logic               tick,
    output logic [PRESC_W-1:0] pre_q
);

    // A compare of greater-or-equal keeps a lowered divisor from wrapping
    always_comb tick = en && (pre_q >= divisor);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wr_value,
    input  logic              tick,
    input  logic              reload,
    input  logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              zero_evt
);

    logic [DATA_W-1:0] cnt_d;

    always_comb begin
        cnt_d    = cnt_q;
        zero_evt = 1'b0;
        if (wr_load) begin
            cnt_d = wr_value;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_d = reload ? load_q : '0;
            end else begin
                cnt_d    = cnt_q - DATA_W'(1);
                zero_evt = (cnt_q == DATA_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              zero_evt,
    output logic              wr_load,
    output logic [DATA_W-1:0] load_q,
    output ctrl_t             ctrl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e sel;
    logic     wr_ctrl;
    logic     clr_flag;

    always_comb begin
        sel      = decode_off(16'(bus_addr));
        wr_load  = bus_we && (sel == SEL_LOAD);
        wr_ctrl  = bus_we && (sel == SEL_CTRL);
        clr_flag = bus_we && (sel == SEL_STAT) && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_load) load_q <= bus_wdata;
            if (wr_ctrl) ctrl_q <= ctrl_from_bits(bus_wdata[15:0]);
            // Hardware set outranks a software clear in the same cycle
            if (zero_evt)      flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (sel)
            SEL_LOAD:  bus_rdata = load_q;
            SEL_COUNT: bus_rdata = cnt_q;
            SEL_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            SEL_STAT:  bus_rdata = DATA_W'(flag_q);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic               wr_load;
    logic [DATA_W-1:0]  load_q;
    logic [DATA_W-1:0]  cnt_q;
    ctrl_t              ctrl_q;
    logic               flag_q;
    logic               zero_evt;
    logic               tick;
    logic [PRESC_W-1:0] pre_q;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .zero_evt  (zero_evt),
        .wr_load   (wr_load),
        .load_q    (load_q),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q),
        .bus_rdata (bus_rdata)
    );

    cdt_prescale u_presc (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.run),
        .clr     (wr_load),
        .divisor (ctrl_q.prescale),
        .tick    (tick),
        .pre_q   (pre_q)
    );

    cdt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .wr_load  (wr_load),
        .wr_value (bus_wdata),
        .tick     (tick),
        .reload   (ctrl_q.reload),
        .load_q   (load_q),
        .cnt_q    (cnt_q),
        .zero_evt (zero_evt)
    );

    assign irq = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [DATA_W-1:0]  cnt_q,
    input logic [DATA_W-1:0]  load_q,
    input logic               run,
    input logic               reload,
    input logic               flag_q,
    input logic               tick,
    input logic [PRESC_W-1:0] pre_q
);

    logic ld_wr;
    logic st_clr;
    logic mapped;

    always_comb begin
        ld_wr  = bus_we && (16'(bus_addr) == OFF_LOAD);
        st_clr = bus_we && (16'(bus_addr) == OFF_STAT) && bus_wdata[0];
        mapped = (16'(bus_addr) == OFF_LOAD) || (16'(bus_addr) == OFF_COUNT) ||
                 (16'(bus_addr) == OFF_CTRL) || (16'(bus_addr) == OFF_STAT);
    end

    assert_load_write_R2: assert property (@(posedge clk) disable iff (rst)
        ld_wr |=> (cnt_q == $past(bus_wdata)) && (load_q == $past(bus_wdata)));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && cnt_q != '0) |=>
            (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - DATA_W'(1)));

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && !run) |=> $stable(cnt_q));

    assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
        tick |-> run);

    assert_presc_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ld_wr || !run) |=> (pre_q == '0));

    assert_park_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !reload && !ld_wr) |=> (cnt_q == '0));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_wr && cnt_q == DATA_W'(1)) |=> flag_q);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (st_clr && !(tick && !ld_wr && cnt_q == DATA_W'(1))) |=> !flag_q);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (bus_rdata == '0));

endmodule

bind cdt_timer cdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .load_q    (load_q),
    .run       (ctrl_q.run),
    .reload    (ctrl_q.reload),
    .flag_q    (flag_q),
    .tick      (tick),
    .pre_q     (pre_q)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_load = 0, m_count = 0, m_ctrl = 0;
    logic        m_flag = 0;
    int          m_pre = 0;

    always #10 clk = ~clk;   // 50 MHz

    cdt_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_load;
            8'h04:   return m_count;
            8'h08:   return m_ctrl;
            8'h0C:   return {31'b0, m_flag};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update(input logic [7:0] a, input logic w, input logic [31:0] d);
        bit is_ld   = w && (a == 8'h00);
        bit running = m_ctrl[0];
        int divv    = int'(m_ctrl[15:8]);
        bit t       = running && (m_pre >= divv);
        bit ev      = 0;
        logic [31:0] nc = m_count;
        if (is_ld) nc = d;
        else if (t) begin
            if (m_count == 0) nc = m_ctrl[1] ? m_load : 32'h0;
            else begin
                nc = m_count - 1;
                ev = (m_count == 1);
            end
        end
        m_pre = (is_ld || !running || t) ? 0 : m_pre + 1;
        if (ev) m_flag = 1'b1;
        else if (w && a == 8'h0C && d[0]) m_flag = 1'b0;
        if (is_ld) m_load = d;
        if (w && a == 8'h08) m_ctrl = d & 32'h0000_FF07;
        m_count = nc;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One bus cycle: starts and ends at a falling edge
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
        bus_addr = a; bus_we = w; bus_wdata = d;
        #1;
        check(bus_rdata, model_read(a), "rdata");
        check({31'b0, irq}, {31'b0, m_flag && m_ctrl[2]}, "irq");
        @(posedge clk);
        model_update(a, w, d);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(a, 1'b1, d);
    endtask

    task automatic idle(input int n, input logic [7:0] a);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'h0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values on every register and irq
        cur_req = "R1";
        idle(1, 8'h00); idle(1, 8'h04); idle(1, 8'h08); idle(1, 8'h0C);

        // R10: only run/reload/irq_en/prescale bits are kept
        cur_req = "R10";
        wr(8'h08, 32'hFFFF_FFF8);
        idle(1, 8'h08);
        wr(8'h08, 32'h0000_0000);

        // R2: load write lands in both load and count; R3: stopped count holds
        cur_req = "R2";
        wr(8'h00, 32'd5);
        idle(1, 8'h00); idle(1, 8'h04);
        cur_req = "R3";
        idle(4, 8'h04);

        // R3/R6/R9: run at P=0, one-shot, reaches zero, flag set but irq masked
        cur_req = "R6";
        wr(8'h08, 32'h0000_0001);
        idle(8, 8'h04);
        idle(1, 8'h0C);
        cur_req = "R9";
        wr(8'h08, 32'h0000_0005);
        idle(2, 8'h0C);

        // R7: zero write ignored, one write clears
        cur_req = "R7";
        wr(8'h0C, 32'h0000_0000);
        idle(1, 8'h0C);
        wr(8'h0C, 32'h0000_0001);
        idle(2, 8'h0C);

        // R4: prescale by 4 with interrupt enabled
        cur_req = "R4";
        wr(8'h08, 32'h0000_0304);
        wr(8'h00, 32'd4);
        wr(8'h08, 32'h0000_0305);
        idle(24, 8'h04);
        wr(8'h0C, 32'h1);

        // R4: load write mid-period restarts the prescaler (P=7)
        wr(8'h08, 32'h0000_0701);
        wr(8'h00, 32'd10);
        idle(5, 8'h04);
        wr(8'h00, 32'd10);
        idle(20, 8'h04);

        // R3: disabling mid-count freezes it, re-enabling restarts prescaler
        cur_req = "R3";
        wr(8'h08, 32'h0000_0700);
        idle(6, 8'h04);
        wr(8'h08, 32'h0000_0701);
        idle(12, 8'h04);

        // R4: divide-by-64
        cur_req = "R4";
        wr(8'h08, 32'h0000_3F00);
        wr(8'h00, 32'd2);
        wr(8'h08, 32'h0000_3F05);
        idle(140, 8'h04);
        wr(8'h0C, 32'h1);

        // R5: periodic refill, P=0, load 3
        cur_req = "R5";
        wr(8'h08, 32'h0000_0000);
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h0000_0007);
        idle(14, 8'h04);

        // R8: clear writes every cycle collide with periodic sets
        cur_req = "R8";
        for (int i = 0; i < 12; i++) wr(8'h0C, 32'h1);
        idle(2, 8'h0C);

        // R5: one-shot parks at zero even with ticks continuing
        cur_req = "R5";
        wr(8'h08, 32'h0000_0001);
        idle(10, 8'h04);

        // R11: unmapped reads are zero; stray and count-offset writes ignored
        cur_req = "R11";
        wr(8'h08, 32'h0000_0000);
        idle(1, 8'h10); idle(1, 8'h3C); idle(1, 8'h02); idle(1, 8'hFC);
        wr(8'h10, 32'hDEAD_BEEF);
        wr(8'h04, 32'h0000_0123);
        wr(8'h0E, 32'hFFFF_FFFF);
        idle(1, 8'h00); idle(1, 8'h04); idle(1, 8'h08); idle(1, 8'h0C);

        finish_run();
    end

endmodule